// File: doc/BRIEF.md
# UART Register Front End with Receive Queue

This block is the register side of a serial port. A host reaches it through a simple word-addressed read/write port. Received bytes come in on a valid/ready byte stream, and transmitted bytes leave on a one-cycle valid strobe. The bit-level shifting, baud timing and DMA engines sit outside the block. Inside there is a 16-entry receive queue, a status flag word, a two-source interrupt unit with mask, raw, masked and clear views, six plain holding registers that outside logic uses as configuration, and a read-only window of eight identification bytes at the top of the address space.

The receive path has two modes, selected by bit 4 of the line-control holding register. When the bit is set, the queue holds up to sixteen bytes. When it is clear, the queue holds a single byte and the input is back-pressured until that byte is read. Read data is combinational from the current state. A read of the data word removes the oldest byte at the next clock edge.

The single interrupt output is high whenever any raw interrupt bit is also enabled in the mask.

Top module: `uart_regfront`

## Requirements
- R1: Reset state. The flag word (word 6) reads 0x90. Control (word 12) reads 0x300 and level select (word 13) reads 0x12. The divisors, line control, DMA control, mask, raw and masked words read 0. The irq and tx_valid outputs are low and rx_ready is high.
- R2: Words 9, 10, 11, 12, 13 and 18 are holding registers. Each reads back the full 32-bit value last written to it.
- R3: Words 0x3F8 to 0x3FF return, in address order, the identification bytes 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended.
- R4: With line-control bit 4 set, up to 16 bytes are accepted and rx_ready is low at 16. Flag bit 6 (receive full) is 1 exactly while 16 bytes are held.
- R5: With line-control bit 4 clear, one byte is held and rx_ready is low while it is held.
- R6: Reading word 0 returns the oldest held byte in bits 7:0 and removes it. Flag bit 4 (receive empty) is 1 exactly when no byte is held. Flag bit 7 (transmit empty) always reads 1 and flag bit 5 (transmit full) always reads 0.
- R7: A read of word 0 with nothing held returns the most recently removed byte (0 if none since reset) and changes nothing.
- R8: Raw bit 4 (receive) sets when an accepted byte brings occupancy to 1. It clears when a removal brings occupancy to 0. When a push and a pop happen in the same cycle, the resulting count decides.
- R9: A write to word 0 drives bits 7:0 on tx_byte with tx_valid high for exactly the next cycle, and sets raw bit 5 (transmit).
- R10: Writing word 17 clears each raw bit written as 1. A set event in the same cycle wins over the clear.
- R11: Word 14 is the 32-bit mask. Word 15 is raw, word 16 is raw AND mask, and irq is high exactly when the masked word is nonzero.
- R12: The flag, raw and masked words ignore writes. Reads of unassigned words, and of word 17, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of word 0 removes a byte) |
| addr | input | 10 | Word offset (byte address divided by four) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| rx_valid | input | 1 | Received byte offered |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Queue can take a byte this cycle |
| tx_valid | output | 1 | One-cycle strobe for a transmitted byte |
| tx_byte | output | 8 | Transmitted byte |
| irq | output | 1 | OR of masked interrupt sources |

## Verification
The queue is driven through several patterns. A single byte is offered for several cycles in holding mode, which shows whether back-pressure starts after one byte. In queue mode a burst of eighteen bytes is offered, which exposes the full boundary, the two refused bytes and the ordering on drain. A pop from an empty queue separates "return last removed byte" from a stale slot or an underflow. Same-cycle push and pop, and a clear write together with a set event, show which of the conflicting updates wins in the count and in the raw interrupt bit.

// File: rtl/uart_rf_pkg.sv
// Package: word offsets, bit positions, reset values and the identification
// bytes shared by the UART register front end and its checker.
package uart_rf_pkg;

    localparam int OFF_DATA = 0;
    localparam int OFF_FLAG = 6;
    localparam int OFF_MASK = 14;
    localparam int OFF_RAW  = 15;
    localparam int OFF_MIS  = 16;
    localparam int OFF_ICLR = 17;

    localparam int IRQ_RX_BIT  = 4;
    localparam int IRQ_TX_BIT  = 5;
    localparam int QUEUE_EN_BIT = 4;

    localparam int NHOLD    = 6;
    localparam int HOLD_LCR = 2;

    // Word offset of holding register i.
    function automatic int hold_off(input int i);
        case (i)
            0:       return 9;
            1:       return 10;
            2:       return 11;
            3:       return 12;
            4:       return 13;
            default: return 18;
        endcase
    endfunction

    // Reset value of holding register i.
    function automatic logic [31:0] hold_rst(input int i);
        case (i)
            3:       return 32'h0000_0300;
            4:       return 32'h0000_0012;
            default: return 32'h0;
        endcase
    endfunction

    // Identification byte at window index idx.
    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h11;
            3'd1:    return 8'h10;
            3'd2:    return 8'h14;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/uart_rf_hreg.sv
// Holding register: a plain read/write word with a parameterised reset value.
// Assumes the write enable has already been decoded for this register.
module uart_rf_hreg #(
    parameter int          W   = 32,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Load on write, return to the reset value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST;
        else if (we) q <= d;
    end

endmodule

// File: rtl/uart_rf_rxfifo.sv
// Receive queue: a ring buffer of DEPTH bytes. It accepts bytes while the
// occupancy is below its capacity, which is DEPTH in queue mode and 1 in
// holding mode. It also keeps the most recently removed byte, which is
// returned by a removal from an empty queue.
// Assumes DEPTH >= 2.
module uart_rf_rxfifo #(
    parameter int  DEPTH  = 16,
    parameter int  BYTE_W = 8,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              queue_mode,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    input  logic              pop_req,
    output logic [BYTE_W-1:0] head_byte,
    output logic              accepted,
    output logic              popped,
    output logic [CNT_W-1:0]  occ
);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  occ_q;
    logic [BYTE_W-1:0] last_q;
    logic [CNT_W-1:0]  cap;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Capacity, handshake and head byte.
    always_comb begin
        cap       = queue_mode ? CNT_W'(DEPTH) : CNT_W'(1);
        in_ready  = occ_q < cap;
        accepted  = in_valid && in_ready;
        popped    = pop_req && (occ_q != '0);
        head_byte = (occ_q == '0) ? last_q : mem[rd_ptr];
        occ       = occ_q;
    end

    // Storage write for accepted bytes.
    always_ff @(posedge clk) begin
        if (accepted) mem[wr_ptr] <= in_byte;
    end

    // Pointers, occupancy and the last removed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ_q  <= '0;
            last_q <= '0;
        end else begin
            if (accepted) wr_ptr <= ptr_next(wr_ptr);
            if (popped) begin
                rd_ptr <= ptr_next(rd_ptr);
                last_q <= mem[rd_ptr];
            end
            occ_q <= occ_q + CNT_W'(accepted) - CNT_W'(popped);
        end
    end

endmodule

// File: rtl/uart_rf_irq.sv
// Interrupt unit: two raw sources (receive, transmit), a full-width mask,
// write-one-to-clear, and the OR of the masked sources. A set event has
// priority over a clear in the same cycle.
module uart_rf_irq #(
    parameter int DATA_W = 32,
    parameter int RX_BIT = 4,
    parameter int TX_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rx_set,
    input  logic              rx_drop,
    input  logic              tx_set,
    output logic [DATA_W-1:0] raw_word,
    output logic [DATA_W-1:0] mask_q,
    output logic              irq
);

    localparam int NSRC = 2;

    logic [NSRC-1:0] set_v, drop_v, raw_q;

    assign set_v  = {tx_set, rx_set};
    assign drop_v = {1'b0, rx_drop};

    // One flop per source; source 0 sits at RX_BIT, source 1 at TX_BIT.
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        localparam int POS = (g == 0) ? RX_BIT : TX_BIT;
        // Set wins; otherwise a drop event or a written one clears.
        always_ff @(posedge clk) begin
            if (!rst_n)
                raw_q[g] <= 1'b0;
            else if (set_v[g])
                raw_q[g] <= 1'b1;
            else if (drop_v[g] || (clr_we && wdata[POS]))
                raw_q[g] <= 1'b0;
        end
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata;
    end

    // Place the raw bits in the word and form the output.
    always_comb begin
        raw_word         = '0;
        raw_word[RX_BIT] = raw_q[0];
        raw_word[TX_BIT] = raw_q[1];
        irq              = |(raw_word & mask_q);
    end

endmodule

// File: rtl/uart_regfront.sv
// UART register front end (top). It decodes word-addressed reads and writes,
// drives the transmit strobe, forms the flag word and the identification
// window, and ties together the receive queue, the interrupt unit and the
// holding registers. Read data is combinational. A read of word 0 removes a
// byte at the next edge. Assumes the host does not rely on wr_en and rd_en
// to the same word in one cycle.
module uart_regfront #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 10,
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 16,
    parameter int TRIG   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [OFF_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              irq
);

    import uart_rf_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] hold_q [NHOLD];
    logic [DATA_W-1:0] raw_word, mask_q, flag_word;
    logic [BYTE_W-1:0] head_byte;
    logic [CNT_W-1:0]  rx_occ, occ_next;
    logic              queue_mode, data_wr, data_rd, accepted, popped;
    logic              rx_set, rx_drop, id_hit;

    assign data_wr    = wr_en && (addr == OFF_W'(OFF_DATA));
    assign data_rd    = rd_en && (addr == OFF_W'(OFF_DATA));
    assign queue_mode = hold_q[HOLD_LCR][QUEUE_EN_BIT];
    assign id_hit     = &addr[OFF_W-1:3];

    // Holding registers, one instance per configured word.
    for (genvar i = 0; i < NHOLD; i++) begin : g_hold
        uart_rf_hreg #(
            .W   (DATA_W),
            .RST (DATA_W'(hold_rst(i)))
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en && (addr == OFF_W'(hold_off(i)))),
            .d     (wdata),
            .q     (hold_q[i])
        );
    end

    uart_rf_rxfifo #(
        .DEPTH  (DEPTH),
        .BYTE_W (BYTE_W)
    ) u_rxq (
        .clk        (clk),
        .rst_n      (rst_n),
        .queue_mode (queue_mode),
        .in_valid   (rx_valid),
        .in_byte    (rx_byte),
        .in_ready   (rx_ready),
        .pop_req    (data_rd),
        .head_byte  (head_byte),
        .accepted   (accepted),
        .popped     (popped),
        .occ        (rx_occ)
    );

    // Receive interrupt events from the occupancy after this cycle.
    always_comb begin
        occ_next = rx_occ + CNT_W'(accepted) - CNT_W'(popped);
        rx_set   = accepted && (occ_next == CNT_W'(TRIG));
        rx_drop  = popped && (occ_next == CNT_W'(TRIG - 1));
    end

    uart_rf_irq #(
        .DATA_W (DATA_W),
        .RX_BIT (IRQ_RX_BIT),
        .TX_BIT (IRQ_TX_BIT)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_we  (wr_en && (addr == OFF_W'(OFF_MASK))),
        .clr_we   (wr_en && (addr == OFF_W'(OFF_ICLR))),
        .wdata    (wdata),
        .rx_set   (rx_set),
        .rx_drop  (rx_drop),
        .tx_set   (data_wr),
        .raw_word (raw_word),
        .mask_q   (mask_q),
        .irq      (irq)
    );

    // Transmit strobe: one cycle after each data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= data_wr;
            if (data_wr) tx_byte <= wdata[BYTE_W-1:0];
        end
    end

    // Flag word: transmit side always empty, receive side from occupancy.
    always_comb begin
        flag_word    = '0;
        flag_word[7] = 1'b1;
        flag_word[6] = (rx_occ == CNT_W'(DEPTH));
        flag_word[5] = 1'b0;
        flag_word[4] = (rx_occ == '0);
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        if (id_hit) begin
            rdata = DATA_W'(id_byte(addr[2:0]));
        end else begin
            case (int'(addr))
                OFF_DATA: rdata = DATA_W'(head_byte);
                OFF_FLAG: rdata = flag_word;
                OFF_MASK: rdata = mask_q;
                OFF_RAW:  rdata = raw_word;
                OFF_MIS:  rdata = raw_word & mask_q;
                default:  rdata = '0;
            endcase
            for (int i = 0; i < NHOLD; i++) begin
                if (addr == OFF_W'(hold_off(i))) rdata = hold_q[i];
            end
        end
    end

endmodule

// File: rtl/uart_regfront_chk.sv
// Checker for the UART register front end, bound into every instance.
// It watches the port handshakes together with the queue occupancy and the
// receive raw bit.
module uart_regfront_chk #(
    parameter int OFF_W  = 10,
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [OFF_W-1:0]  addr,
    input logic [BYTE_W-1:0] wbyte,
    input logic              in_valid,
    input logic              in_ready,
    input logic              tx_valid,
    input logic [BYTE_W-1:0] tx_byte,
    input logic [CNT_W-1:0]  occ,
    input logic              queue_mode,
    input logic              raw_rx
);

    logic pop_try, push_ok;
    assign pop_try = rd_en && (addr == '0);
    assign push_ok = in_valid && in_ready;

    // R4: occupancy never exceeds the queue depth.
    a_r4_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    // R5: in holding mode a held byte blocks the input.
    a_r5_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!queue_mode && occ != '0) |-> !in_ready);

    // R6: a removal without a push lowers occupancy by one.
    a_r6_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_try && occ != '0 && !push_ok) |=> occ == $past(occ) - CNT_W'(1));

    // R7: a removal from an empty queue leaves it empty.
    a_r7_empty_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_try && occ == '0 && !push_ok) |=> occ == '0);

    // R8: a byte arriving at an empty queue raises the receive raw bit.
    a_r8_rx_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && occ == '0) |=> raw_rx);

    // R9: a data write appears on the transmit strobe next cycle.
    a_r9_tx_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0) |=> (tx_valid && tx_byte == $past(wbyte)));

endmodule

bind uart_regfront uart_regfront_chk #(
    .OFF_W  (OFF_W),
    .BYTE_W (BYTE_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wbyte      (wdata[BYTE_W-1:0]),
    .in_valid   (rx_valid),
    .in_ready   (rx_ready),
    .tx_valid   (tx_valid),
    .tx_byte    (tx_byte),
    .occ        (rx_occ),
    .queue_mode (queue_mode),
    .raw_rx     (raw_word[4])
);

// File: tb/tb_uart_regfront.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model (byte queue, plain variables) that is
// stepped once per clock and compared with the design at every falling edge.
module tb_uart_regfront;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, rx_valid = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [7:0]  rx_byte = '0;
    logic [31:0] rdata;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_byte;

    int  vectors = 0;
    int  misses  = 0;
    bit  done    = 0;

    always #4 clk = ~clk;

    uart_regfront dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
    );

    // Reference model state.
    logic [7:0]  q[$];
    logic [31:0] m_ibrd = 0, m_fbrd = 0, m_lcr = 0, m_cr = 32'h300;
    logic [31:0] m_ifls = 32'h12, m_dma = 0, m_mask = 0, m_raw = 0;
    logic [7:0]  m_last = 0, m_txd = 0;
    bit          m_txv = 0;
    logic [7:0]  ids [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    function automatic bit m_ready();
        return (m_lcr[4] ? q.size() < 16 : q.size() < 1);
    endfunction

    function automatic logic [31:0] m_read(input int a);
        if (a >= 'h3F8 && a <= 'h3FF) return {24'h0, ids[a - 'h3F8]};
        case (a)
            0:  return {24'h0, (q.size() > 0) ? q[0] : m_last};
            6:  return 32'h80 | ((q.size() == 16) ? 32'h40 : 0) | ((q.size() == 0) ? 32'h10 : 0);
            9:  return m_ibrd;
            10: return m_fbrd;
            11: return m_lcr;
            12: return m_cr;
            13: return m_ifls;
            14: return m_mask;
            15: return m_raw;
            16: return m_raw & m_mask;
            18: return m_dma;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock: drive, compare at the falling edge, advance the model.
    task automatic step(input bit wr, input bit rd, input int a, input logic [31:0] d,
                        input bit rv, input logic [7:0] rb, input string tag);
        bit push, pop;
        wr_en = wr; rd_en = rd; addr = 10'(a); wdata = d; rx_valid = rv; rx_byte = rb;
        @(negedge clk);
        chk("rx_ready", {31'h0, rx_ready}, {31'h0, m_ready()}, tag);
        chk("irq", {31'h0, irq}, {31'h0, |(m_raw & m_mask)}, tag);
        chk("tx_valid", {31'h0, tx_valid}, {31'h0, m_txv}, tag);
        if (m_txv) chk("tx_byte", {24'h0, tx_byte}, {24'h0, m_txd}, tag);
        if (rd) chk($sformatf("rdata[%0d]", a), rdata, m_read(a), tag);
        push = rv && m_ready();
        pop  = rd && a == 0 && q.size() > 0;
        m_txv = 0;
        if (wr) begin
            case (a)
                0:  begin m_txv = 1; m_txd = d[7:0]; end
                9:  m_ibrd = d;
                10: m_fbrd = d;
                11: m_lcr = d;
                12: m_cr = d;
                13: m_ifls = d;
                14: m_mask = d;
                17: m_raw = m_raw & ~d;
                18: m_dma = d;
                default: ;
            endcase
        end
        if (pop)  m_last = q.pop_front();
        if (push) q.push_back(rb);
        if (push && q.size() == 1)     m_raw = m_raw | 32'h10;
        else if (pop && q.size() == 0) m_raw = m_raw & ~32'h10;
        if (wr && a == 0) m_raw = m_raw | 32'h20;
        @(posedge clk); #1;
    endtask

    task automatic wr(input int a, input logic [31:0] d, input string tag);
        step(1, 0, a, d, 0, 8'h0, tag);
    endtask
    task automatic rd(input int a, input string tag);
        step(0, 1, a, 0, 0, 8'h0, tag);
    endtask
    task automatic rx(input logic [7:0] b, input string tag);
        step(0, 0, 0, 0, 1, b, tag);
    endtask

    initial begin
        int hold_offs [6] = '{9, 10, 11, 12, 13, 18};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values of every readable word.
        foreach (hold_offs[i]) rd(hold_offs[i], "R1");
        rd(6, "R1"); rd(14, "R1"); rd(15, "R1"); rd(16, "R1");

        // R12: unassigned and write-ignored words.
        rd(1, "R12"); rd(7, "R12"); rd(17, "R12"); rd(32, "R12");
        wr(6, 32'h0, "R12"); rd(6, "R12");
        wr(15, 32'hFF, "R12"); rd(15, "R12");
        wr(16, 32'hFF, "R12"); rd(16, "R12");

        // R2: holding registers keep full words.
        foreach (hold_offs[i]) begin
            wr(hold_offs[i], 32'hA5C3_0000 + (i * 32'h1111), "R2");
            rd(hold_offs[i], "R2");
        end
        wr(11, 32'hFFFF_FFEF, "R2"); rd(11, "R2");

        // R3: identification window.
        for (int i = 0; i < 8; i++) rd('h3F8 + i, "R3");

        // R5: holding mode takes one byte.
        wr(11, 32'h0, "R5");
        rx(8'hA5, "R5"); rx(8'h5A, "R5"); rx(8'h3C, "R5");
        rd(6, "R6");
        rd(0, "R6"); rd(6, "R6");
        // R7: removal from empty returns the last removed byte.
        rd(0, "R7"); rd(6, "R7");

        // R4: queue mode, burst of eighteen offers.
        wr(11, 32'h10, "R4");
        for (int i = 0; i < 18; i++) rx(8'h30 + 8'(i), "R4");
        rd(6, "R4");
        wr(14, 32'h10, "R11"); rd(16, "R11");
        for (int i = 0; i < 8; i++) rd(0, "R6");
        rd(6, "R6");
        for (int i = 0; i < 8; i++) rd(0, "R6");
        rd(15, "R8"); rd(0, "R7"); rd(6, "R6");

        // R9: transmit strobe and raw bit.
        wr(0, 32'h1C3, "R9"); wr(0, 32'h55, "R9"); step(0, 0, 0, 0, 0, 0, "R9");
        rd(15, "R9");
        wr(14, 32'h20, "R11"); rd(16, "R11");
        // R10: write-one-to-clear.
        wr(17, 32'h10, "R10"); rd(15, "R10");
        wr(17, 32'h20, "R10"); rd(15, "R10");

        // R8: same-cycle push and pop keep the receive bit; then drain.
        wr(14, 32'h30, "R8");
        rx(8'h77, "R8");
        step(0, 1, 0, 0, 1, 8'h88, "R8");
        rd(15, "R8"); rd(0, "R8"); rd(15, "R8");

        // R10: set event wins over a clear in the same cycle.
        step(1, 0, 17, 32'h10, 1, 8'h99, "R10"); rd(15, "R10");
        step(1, 0, 0, 32'h66, 0, 8'h0, "R10"); wr(17, 32'h30, "R10"); rd(15, "R10");
        step(1, 0, 17, 32'h20, 0, 8'h0, "R10"); rd(15, "R10");

        // R11: mask word read back and masked view.
        wr(14, 32'hA5A5_A5E0, "R11"); rd(14, "R11"); rd(16, "R11");
        wr(14, 32'h0, "R11"); rd(16, "R11");
        rd(0, "R6"); rd(6, "R6");

        step(0, 0, 0, 0, 0, 0, "R1");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 200000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule